// File: doc/BRIEF.md
# Bidirectional Dual-Clock FIFO Pair

This block joins two independently clocked ports, A and B, through two first-in first-out queues that run in opposite directions. The forward queue takes 36-bit words written at port A and hands them out at port B. The return queue takes words written at port B and hands them out at port A. Each queue is 64 words deep by default. The write side and the read side of each queue run on different clocks.

Each port has four control inputs: an active-low select, a direction bit, a mailbox bit and an enable. One decoder per port turns these into at most one transfer per clock edge. The transfer is either a write into the queue that the port feeds or a read from the queue that the port drains. When the mailbox bit is set, the port does nothing.

Each port shows three flags:
- a full flag for the queue it writes,
- an active-low almost-full flag for the queue it writes,
- an empty flag for the queue it reads.

The almost-full flag goes low as soon as a write edge brings the queue up to the threshold. It goes high again only after the read that drained the queue has been carried across into the writer's clock.

Pointers cross between the clocks in Gray code. A short chain of flops on the receiving clock captures them. Each pointer carries one bit more than the address, so that a full queue can be told apart from an empty one.

Top module: `bidir_fifo_pair`

## Requirements
- R1: On a rising clk_a edge with a_en=1, a_cs_n=0, a_write=1, a_mbox=0 and a_full=0, the word on a_din is added to the forward queue. Forward words leave at port B in the order they were written.
- R2: On a rising clk_b edge with b_en=1, b_cs_n=0, b_write=0, b_mbox=0 and b_empty=0, the oldest forward word is removed. It appears on b_dout right after that edge and stays there until the next accepted read.
- R3: The return queue mirrors R1 and R2. Port B writes it under b_write=1, and port A reads it under a_write=0. Its words appear on a_dout in the order they were written.
- R4: A port does not touch either queue when its mailbox bit is 1, when its select is 1, or when its enable is 0. Both queues keep their contents, and that port's dout does not change.
- R5: a_full is 1 while the forward queue holds 64 words. A write attempted while a_full is 1 is dropped, and only the 64 words already stored are read out afterwards. b_full does the same for the return queue.
- R6: b_empty is 1 when no forward word is left to read. A read attempted while b_empty is 1 is ignored, and b_dout holds its value. a_empty does the same for the return queue.
- R7: a_afull_n is 0 right after the clk_a write edge that brings the forward queue to 64-X words or more, where X is AF_OFFSET and defaults to 8. It is 1 once the queue has settled at 63-X words or fewer.
- R8: After a port B read brings the forward queue below 64-X words, a_afull_n is still 0 after the first rising clk_a edge that follows. It is 1 after the second or, at the latest, the third such edge.
- R9: b_afull_n follows R7 and R8 for the return queue. It is counted in clk_b edges and released by port A reads.
- R10: While rst_n is 0 across at least two rising edges of each clock, both queues are emptied. During reset the outputs are a_empty=1, b_empty=1, a_full=0, b_full=0, a_afull_n=1, b_afull_n=1, and both douts are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Active-low reset, sampled on both clocks |
| a_cs_n | input | 1 | Port A select, active low |
| a_write | input | 1 | Port A direction: 1 writes the forward queue, 0 reads the return queue |
| a_mbox | input | 1 | Port A mailbox bit; 1 blocks queue access |
| a_en | input | 1 | Port A transfer enable |
| a_din | input | DATA_W | Port A write data |
| a_dout | output | DATA_W | Port A read data from the return queue |
| a_full | output | 1 | Forward queue full |
| a_afull_n | output | 1 | Forward queue almost full, active low |
| a_empty | output | 1 | Return queue empty |
| b_cs_n | input | 1 | Port B select, active low |
| b_write | input | 1 | Port B direction: 1 writes the return queue, 0 reads the forward queue |
| b_mbox | input | 1 | Port B mailbox bit; 1 blocks queue access |
| b_en | input | 1 | Port B transfer enable |
| b_din | input | DATA_W | Port B write data |
| b_dout | output | DATA_W | Port B read data from the forward queue |
| b_full | output | 1 | Return queue full |
| b_afull_n | output | 1 | Return queue almost full, active low |
| b_empty | output | 1 | Forward queue empty |

## Verification
The hardest case to reach is the release of an almost-full flag. The queue must sit exactly at the threshold, a single read must then happen on the far clock, and the flag must be watched edge by edge on the near clock. The two clocks run at periods that never line up, so that edge order is always defined. The stimulus first writes one word short of the threshold and confirms that the flag stays high. It then writes the threshold word, issues one far-side read, and accepts release on the second or third near-side edge. Random traffic then runs on both ports at once, mixing writes, reads, mailbox cycles and idle cycles, and drives the queues into both their full and their empty states.

// File: rtl/bfp_pkg.sv
// Package: shared types and pointer code conversions for the FIFO pair.
// Assumes pointer widths never exceed 32 bits.
package bfp_pkg;

    // Decoded request of one port: at most one bit is set.
    typedef struct packed {
        logic wr;
        logic rd;
    } port_req_t;

    // Binary to reflected Gray code.
    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary.
    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/bfp_port_decode.sv
// Module: bfp_port_decode
// Turns the four control inputs of one port into a write request for the
// queue that port fills or a read request for the queue that port drains.
// Assumes the controls are stable around the port clock edge.
module bfp_port_decode
    import bfp_pkg::*;
(
    input  logic      cs_n,
    input  logic      dir_wr,
    input  logic      mbox,
    input  logic      en,
    output port_req_t req
);

    logic active;

    // A transfer needs enable, select and no mailbox access.
    always_comb begin
        active = en & ~cs_n & ~mbox;
        req.wr = active & dir_wr;
        req.rd = active & ~dir_wr;
    end

endmodule

// File: rtl/bfp_ptr_sync.sv
// Module: bfp_ptr_sync
// Carries a Gray-coded pointer into another clock through a chain of flops.
// Assumes the input changes by at most one bit per source clock cycle.
module bfp_ptr_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);

    logic [W-1:0] stg [STAGES];

    // First stage captures the foreign pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d_in;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        // Each later stage re-times the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
        end
    end

    assign q_out = stg[STAGES-1];

endmodule

// File: rtl/bfp_wr_side.sv
// Module: bfp_wr_side
// Write pointer, full flag and almost-full flag of one queue, all on the
// write clock. The read pointer arrives already synchronised in Gray code.
// Assumes 0 <= AF_OFFSET < 2**AW.
module bfp_wr_side
    import bfp_pkg::*;
#(
    parameter int AW        = 6,
    parameter int AF_OFFSET = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [AW:0]   rq_gray,
    output logic [AW:0]   wgray,
    output logic [AW-1:0] waddr,
    output logic          wr_acc,
    output logic          full,
    output logic          afull_n
);

    localparam int PW       = AW + 1;
    localparam int DEPTH    = 1 << AW;
    localparam int AF_LEVEL = DEPTH - AF_OFFSET;

    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nxt;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] wcount;

    // Flags are decoded from registered pointers only.
    always_comb begin
        rbin_s   = PW'(gray2bin(32'(rq_gray)));
        wcount   = wbin - rbin_s;
        full     = (wgray == {~rq_gray[PW-1:PW-2], rq_gray[PW-3:0]});
        wr_acc   = wr_req & ~full;
        wbin_nxt = wbin + PW'(1);
        afull_n  = (wcount < PW'(AF_LEVEL));
        waddr    = wbin[AW-1:0];
    end

    // Advance the binary and Gray write pointers on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr_acc) begin
            wbin  <= wbin_nxt;
            wgray <= PW'(bin2gray(32'(wbin_nxt)));
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wcount <= PW'(DEPTH)); // R5
    AST_FULL_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_req) |=> $stable(wgray)); // R5
    AST_FULL_IMPLIES_AFULL: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !afull_n); // R7
    AST_WGRAY_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wgray ^ $past(wgray))); // R1

endmodule

// File: rtl/bfp_rd_side.sv
// Module: bfp_rd_side
// Read pointer and empty flag of one queue, on the read clock. The write
// pointer arrives already synchronised in Gray code.
// Assumes the write pointer moves by one Gray step at a time.
module bfp_rd_side
    import bfp_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [AW:0]   wq_gray,
    output logic [AW:0]   rgray,
    output logic [AW-1:0] raddr,
    output logic          rd_acc,
    output logic          empty
);

    localparam int PW = AW + 1;

    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nxt;

    // Empty when both pointers are equal; a read is taken only when data is present.
    always_comb begin
        empty    = (rgray == wq_gray);
        rd_acc   = rd_req & ~empty;
        rbin_nxt = rbin + PW'(1);
        raddr    = rbin[AW-1:0];
    end

    // Advance the binary and Gray read pointers on an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (rd_acc) begin
            rbin  <= rbin_nxt;
            rgray <= PW'(bin2gray(32'(rbin_nxt)));
        end
    end

    AST_EMPTY_DROPS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_req) |=> $stable(rgray)); // R6
    AST_RGRAY_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rgray ^ $past(rgray))); // R2

endmodule

// File: rtl/bfp_fifo_core.sv
// Module: bfp_fifo_core
// One dual-clock queue: the storage array, the write and read pointer logic,
// and the pointer synchronisers in both directions. Read data is registered
// on the read clock.
// Assumes rst_n is held low across several edges of both clocks.
module bfp_fifo_core #(
    parameter int DW          = 36,
    parameter int AW          = 6,
    parameter int AF_OFFSET   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] din,
    output logic          full,
    output logic          afull_n,
    input  logic          rd_req,
    output logic [DW-1:0] dout,
    output logic          empty
);

    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wgray, rgray, wq_gray, rq_gray;
    logic [AW-1:0] waddr, raddr;
    logic          wr_acc, rd_acc;

    bfp_wr_side #(.AW(AW), .AF_OFFSET(AF_OFFSET)) u_wr (
        .clk(wclk), .rst_n(rst_n), .wr_req(wr_req), .rq_gray(rq_gray),
        .wgray(wgray), .waddr(waddr), .wr_acc(wr_acc),
        .full(full), .afull_n(afull_n)
    );

    bfp_rd_side #(.AW(AW)) u_rd (
        .clk(rclk), .rst_n(rst_n), .rd_req(rd_req), .wq_gray(wq_gray),
        .rgray(rgray), .raddr(raddr), .rd_acc(rd_acc), .empty(empty)
    );

    bfp_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .d_in(rgray), .q_out(rq_gray)
    );

    bfp_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .d_in(wgray), .q_out(wq_gray)
    );

    // Store an accepted word at the write address.
    always_ff @(posedge wclk) begin
        if (wr_acc) mem[waddr] <= din;
    end

    // Register the oldest word out on an accepted read.
    always_ff @(posedge rclk) begin
        if (!rst_n)      dout <= '0;
        else if (rd_acc) dout <= mem[raddr];
    end

    AST_DOUT_HOLDS: assert property (@(posedge rclk) disable iff (!rst_n)
        !rd_acc |=> $stable(dout)); // R6

endmodule

// File: rtl/bidir_fifo_pair.sv
// Module: bidir_fifo_pair
// Two opposite-direction dual-clock queues between port A and port B.
// Each port decodes its controls once and sends the request either into the
// queue it fills or to the queue it drains.
// Assumes rst_n is held low for at least two edges of each clock.
module bidir_fifo_pair
    import bfp_pkg::*;
#(
    parameter int DATA_W    = 36,
    parameter int ADDR_W    = 6,
    parameter int AF_OFFSET = 8
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              rst_n,
    input  logic              a_cs_n,
    input  logic              a_write,
    input  logic              a_mbox,
    input  logic              a_en,
    input  logic [DATA_W-1:0] a_din,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_full,
    output logic              a_afull_n,
    output logic              a_empty,
    input  logic              b_cs_n,
    input  logic              b_write,
    input  logic              b_mbox,
    input  logic              b_en,
    input  logic [DATA_W-1:0] b_din,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_full,
    output logic              b_afull_n,
    output logic              b_empty
);

    localparam int SYNC_STAGES = 2;

    port_req_t a_req, b_req;

    bfp_port_decode u_dec_a (
        .cs_n(a_cs_n), .dir_wr(a_write), .mbox(a_mbox), .en(a_en), .req(a_req)
    );

    bfp_port_decode u_dec_b (
        .cs_n(b_cs_n), .dir_wr(b_write), .mbox(b_mbox), .en(b_en), .req(b_req)
    );

    // Forward queue: written on clk_a, read on clk_b.
    bfp_fifo_core #(.DW(DATA_W), .AW(ADDR_W), .AF_OFFSET(AF_OFFSET),
                    .SYNC_STAGES(SYNC_STAGES)) u_fwd (
        .wclk(clk_a), .rclk(clk_b), .rst_n(rst_n),
        .wr_req(a_req.wr), .din(a_din), .full(a_full), .afull_n(a_afull_n),
        .rd_req(b_req.rd), .dout(b_dout), .empty(b_empty)
    );

    // Return queue: written on clk_b, read on clk_a.
    bfp_fifo_core #(.DW(DATA_W), .AW(ADDR_W), .AF_OFFSET(AF_OFFSET),
                    .SYNC_STAGES(SYNC_STAGES)) u_ret (
        .wclk(clk_b), .rclk(clk_a), .rst_n(rst_n),
        .wr_req(b_req.wr), .din(b_din), .full(b_full), .afull_n(b_afull_n),
        .rd_req(a_req.rd), .dout(a_dout), .empty(a_empty)
    );

endmodule

// File: tb/tb_bidir_fifo_pair.sv
`timescale 1ns/1ps
module tb_bidir_fifo_pair;

    localparam int DW    = 36;
    localparam int DEPTH = 64;
    localparam int X     = 8;
    localparam int AFL   = DEPTH - X;

    logic clk_a, clk_b, rst_n;
    logic a_cs_n, a_write, a_mbox, a_en, b_cs_n, b_write, b_mbox, b_en;
    logic [DW-1:0] a_din, b_din, a_dout, b_dout;
    logic a_full, a_afull_n, a_empty, b_full, b_afull_n, b_empty;

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] q1[$];
    logic [DW-1:0] q2[$];
    logic sa_full, sa_empty, sb_full, sb_empty;
    logic [DW-1:0] sa_dout, sb_dout;

    bidir_fifo_pair #(.DATA_W(DW), .ADDR_W(6), .AF_OFFSET(X)) dut (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
        .a_cs_n(a_cs_n), .a_write(a_write), .a_mbox(a_mbox), .a_en(a_en),
        .a_din(a_din), .a_dout(a_dout), .a_full(a_full),
        .a_afull_n(a_afull_n), .a_empty(a_empty),
        .b_cs_n(b_cs_n), .b_write(b_write), .b_mbox(b_mbox), .b_en(b_en),
        .b_din(b_din), .b_dout(b_dout), .b_full(b_full),
        .b_afull_n(b_afull_n), .b_empty(b_empty)
    );

    initial begin
        clk_a = 0;
        forever #10 clk_a = ~clk_a;
    end

    initial begin
        clk_b = 0;
        #3.5;
        forever #13 clk_b = ~clk_b;
    end

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] rnd_word();
        return DW'({$urandom(), $urandom()});
    endfunction

    task automatic a_cycle(input logic cs_n, input logic wr, input logic mb,
                           input logic en, input logic [DW-1:0] d);
        @(negedge clk_a);
        a_cs_n = cs_n; a_write = wr; a_mbox = mb; a_en = en; a_din = d;
        sa_full = a_full; sa_empty = a_empty; sa_dout = a_dout;
        @(posedge clk_a);
        #1;
        a_en = 0; a_cs_n = 1;
    endtask

    task automatic b_cycle(input logic cs_n, input logic wr, input logic mb,
                           input logic en, input logic [DW-1:0] d);
        @(negedge clk_b);
        b_cs_n = cs_n; b_write = wr; b_mbox = mb; b_en = en; b_din = d;
        sb_full = b_full; sb_empty = b_empty; sb_dout = b_dout;
        @(posedge clk_b);
        #1;
        b_en = 0; b_cs_n = 1;
    endtask

    task automatic a_push(input logic [DW-1:0] d);
        a_cycle(0, 1, 0, 1, d);
        if (!sa_full) q1.push_back(d);
    endtask

    task automatic b_push(input logic [DW-1:0] d);
        b_cycle(0, 1, 0, 1, d);
        if (!sb_full) q2.push_back(d);
    endtask

    // Read the return queue at port A (R3); an empty read must hold a_dout (R6).
    task automatic a_pop();
        logic [DW-1:0] e;
        a_cycle(0, 0, 0, 1, '0);
        if (!sa_empty) begin
            e = (q2.size() > 0) ? q2.pop_front() : '0;
            chk(a_dout == e, "R3 return order", a_dout, e);
        end else begin
            chk(a_dout == sa_dout, "R6 empty read holds a_dout", a_dout, sa_dout);
        end
    endtask

    // Read the forward queue at port B (R2); an empty read must hold b_dout (R6).
    task automatic b_pop();
        logic [DW-1:0] e;
        b_cycle(0, 0, 0, 1, '0);
        if (!sb_empty) begin
            e = (q1.size() > 0) ? q1.pop_front() : '0;
            chk(b_dout == e, "R2 forward order", b_dout, e);
        end else begin
            chk(b_dout == sb_dout, "R6 empty read holds b_dout", b_dout, sb_dout);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic v;
        void'($urandom(32'd20240611));
        rst_n = 0;
        a_cs_n = 1; a_write = 0; a_mbox = 0; a_en = 0; a_din = '0;
        b_cs_n = 1; b_write = 0; b_mbox = 0; b_en = 0; b_din = '0;
        repeat (6) @(posedge clk_b);
        #2;
        // R10 reset state
        chk(a_empty == 1 && b_empty == 1, "R10 empty in reset", DW'({a_empty, b_empty}), 36'h3);
        chk(a_full == 0 && b_full == 0, "R10 full clear in reset", DW'({a_full, b_full}), 36'h0);
        chk(a_afull_n == 1 && b_afull_n == 1, "R10 afull inactive in reset",
            DW'({a_afull_n, b_afull_n}), 36'h3);
        chk(a_dout == 0 && b_dout == 0, "R10 dout zero in reset", a_dout | b_dout, '0);
        rst_n = 1;

        // R1 and R2: forward queue order
        for (int i = 0; i < 5; i++) a_push(36'h100 + DW'(i));
        repeat (4) @(posedge clk_b);
        #1;
        chk(b_empty == 0, "R1 forward words visible", DW'(b_empty), 36'h0);
        for (int i = 0; i < 5; i++) b_pop();
        chk(b_empty == 1, "R6 forward empty after drain", DW'(b_empty), 36'h1);

        // R3: return queue order
        for (int i = 0; i < 5; i++) b_push(36'hA00 + DW'(i));
        repeat (4) @(posedge clk_a);
        for (int i = 0; i < 5; i++) a_pop();
        chk(a_empty == 1, "R6 return empty after drain", DW'(a_empty), 36'h1);

        // R4: blocked accesses
        a_cycle(0, 1, 1, 1, 36'hDEAD);
        a_cycle(1, 1, 0, 1, 36'hBEEF);
        a_cycle(0, 1, 0, 0, 36'hCAFE);
        repeat (5) @(posedge clk_b);
        #1;
        chk(b_empty == 1, "R4 blocked writes add nothing", DW'(b_empty), 36'h1);
        a_push(36'h777);
        repeat (4) @(posedge clk_b);
        b_cycle(0, 0, 1, 1, '0);
        chk(b_dout == sb_dout, "R4 mailbox read leaves b_dout", b_dout, sb_dout);
        b_cycle(1, 0, 0, 1, '0);
        chk(b_dout == sb_dout, "R4 deselected read leaves b_dout", b_dout, sb_dout);
        b_pop();

        // R7 and R8: forward almost-full threshold and release latency
        for (int i = 0; i < AFL - 1; i++) a_push(36'h2000 + DW'(i));
        repeat (4) @(posedge clk_a);
        #1;
        chk(a_afull_n == 1, "R7 below threshold afull_n high", DW'(a_afull_n), 36'h1);
        a_push(36'h2FFF);
        chk(a_afull_n == 0, "R7 at threshold afull_n low", DW'(a_afull_n), 36'h0);
        b_pop();
        @(posedge clk_a); #1;
        chk(a_afull_n == 0, "R8 still low after first edge", DW'(a_afull_n), 36'h0);
        @(posedge clk_a); #1;
        v = a_afull_n;
        @(posedge clk_a); #1;
        chk(a_afull_n == 1, "R8 released by third edge", DW'(a_afull_n), 36'h1);
        if (v == 0) $display("note: R8 release took the later latency");

        // R5: fill forward queue to full and drop one extra write
        while (q1.size() < DEPTH) a_push(36'h3000 + DW'(q1.size()));
        chk(a_full == 1, "R5 full at 64 words", DW'(a_full), 36'h1);
        a_push(36'hBAD);
        chk(q1.size() == DEPTH, "R5 model holds 64", DW'(q1.size()), DW'(DEPTH));
        repeat (4) @(posedge clk_b);
        for (int i = 0; i < DEPTH; i++) b_pop();
        chk(b_empty == 1, "R5 only 64 words stored", DW'(b_empty), 36'h1);
        b_pop();

        // R9: return almost-full threshold and release latency
        for (int i = 0; i < AFL; i++) b_push(36'h4000 + DW'(i));
        chk(b_afull_n == 0, "R9 at threshold afull_n low", DW'(b_afull_n), 36'h0);
        repeat (4) @(posedge clk_a);
        a_pop();
        @(posedge clk_b); #1;
        chk(b_afull_n == 0, "R9 still low after first edge", DW'(b_afull_n), 36'h0);
        @(posedge clk_b); #1;
        @(posedge clk_b); #1;
        chk(b_afull_n == 1, "R9 released by third edge", DW'(b_afull_n), 36'h1);
        for (int i = 0; i < DEPTH + 4; i++) if (q2.size() > 0) a_pop();

        // Random traffic on both ports at once
        fork
            begin
                for (int i = 0; i < 800; i++) begin
                    case ($urandom % 6)
                        0, 1, 2: a_push(rnd_word());
                        3:       a_pop();
                        4:       a_cycle(0, 1'($urandom), 1, 1, rnd_word());
                        default: a_cycle(1, 1'($urandom), 0, 1, rnd_word());
                    endcase
                end
            end
            begin
                for (int i = 0; i < 600; i++) begin
                    case ($urandom % 6)
                        0, 1:    b_push(rnd_word());
                        2, 3:    b_pop();
                        4:       b_cycle(0, 1'($urandom), 1, 1, rnd_word());
                        default: b_cycle(0, 1'($urandom), 0, 0, rnd_word());
                    endcase
                end
            end
        join
        repeat (6) @(posedge clk_b);
        for (int i = 0; i < DEPTH + 8; i++) if (q1.size() > 0) b_pop();
        for (int i = 0; i < DEPTH + 8; i++) if (q2.size() > 0) a_pop();
        chk(q1.size() == 0, "R1 all forward words delivered", DW'(q1.size()), '0);
        chk(q2.size() == 0, "R3 all return words delivered", DW'(q2.size()), '0);
        repeat (4) @(posedge clk_b);
        #1;
        chk(a_empty == 1 && b_empty == 1, "R6 both empty at end", DW'({a_empty, b_empty}), 36'h3);
        chk(a_afull_n == 1 && b_afull_n == 1, "R7 flags high when empty",
            DW'({a_afull_n, b_afull_n}), 36'h3);

        summary();
        $finish;
    end

endmodule